// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Without Turnaround Cycles

This block is a synthesizable model of a synchronous SRAM whose reads, writes and deselects all move through one two-stage pipeline. The command and address are captured on a clock edge. One enabled edge later, a read fetches its word into an output register. On that same later edge, a write takes its data and byte lanes from the bus. Because a write's data phase lines up with a read's data phase, any sequence of reads, writes and deselects can be issued on consecutive cycles with no idle cycle between them.

The word is 36 bits wide: four lanes, each made of 8 data bits with one parity bit. The data bus is modelled as separate input, output and output-enable signals. A small linear burst counter lets the user continue an access by holding the load control high instead of presenting a new address. The external controller may also generate every address itself and load each one. An active-low clock enable freezes the whole block. An output enable gates the bus drive without any clock.

Top module: `pipe_sram`

## Requirements
- R1: While `rst` is high, and after it falls until the first read has completed, `dq_oe` is 0.
- R2: A read starts on an edge where `clk_en_n`=0, `ld_n`=0, `wr_n`=1 and the device is selected (`sel1_n`=0, `sel2`=1, `sel3_n`=0). After the next enabled edge, `dq_out` holds the stored word at the captured address, and `dq_oe` is 1 while `out_en_n` is 0.
- R3: A write starts under the same conditions with `wr_n`=0. Its data `dq_in` and lane enables `be_n` are sampled on the next enabled edge, not on the address edge.
- R4: Lane i occupies bits [9i+8:9i], with bit 9i+8 as its parity bit. During a write's data edge, lane i is updated only if `be_n[i]`=0; otherwise it keeps its stored value.
- R5: After the enabled edge that follows a write's address edge, `dq_oe` is 0 whatever the value of `out_en_n`.
- R6: A deselect is an enabled edge with `ld_n`=0 and any chip select inactive. It is pipelined: a read issued just before it still drives for one cycle, and after the next enabled edge `dq_oe` is 0.
- R7: `dq_oe` follows `out_en_n` without a clock. It is 0 whenever `out_en_n`=1, and it returns to 1 at once when `out_en_n` falls while a read result is held.
- R8: Reads and writes may alternate on consecutive enabled edges. A read of an address issued on the edge right after a write to it returns the newly written word.
- R9: On an edge with `clk_en_n`=1, nothing changes: `dq_out` and `dq_oe` hold, no memory lane is written, and a pending write still takes its data on the next enabled edge.
- R10: An enabled edge with `ld_n`=1 after a loaded access issues another access of the same type. Its address has the low 2 bits incremented modulo 4 and the upper bits held. The chip selects, `wr_n` and `addr` are ignored on that edge.
- R11: After a deselect, edges with `ld_n`=1 issue no access: nothing is driven and nothing is written until a new address is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock qualifier |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | 0 loads a new address; 1 advances the burst |
| wr_n | input | 1 | 0 write, 1 read, sampled on load edges |
| be_n | input | 4 | Active-low lane enables, sampled on the write data edge |
| addr | input | 6 | Word address |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| dq_in | input | 36 | Write data from the bus |
| dq_out | output | 36 | Registered read data |
| dq_oe | output | 1 | Bus drive enable |

## Verification
A wrong pipeline stage shows up at the port one enabled edge after the command. It appears as a drive during a write data phase, as a missing drive after a read, or as a word from the wrong address. A corrupted burst register first shows as a wrong word on the second beat of a burst. It can also show as a drive after a deselect followed by advance edges. A lane enable decoded wrongly stays hidden in the array until that address is read back. For that reason the lane masks are swept exhaustively and read on the very next cycle.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

endpackage

// File: rtl/pipe_sram_ctrl.sv
module pipe_sram_ctrl
  import pipe_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_en,
  input  logic          sel_ok,
  input  logic          ld_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  output op_e           s1_op,
  output logic [AW-1:0] s1_addr
);

  logic          bst_live;
  logic          bst_wr;
  logic [AW-1:0] bst_addr;
  logic [BW-1:0] lo_nxt;
  logic [AW-1:0] adv_addr;

  // burst wraps inside an aligned group of 2**BW words
  assign lo_nxt   = bst_addr[BW-1:0] + {{(BW-1){1'b0}}, 1'b1};
  assign adv_addr = {bst_addr[AW-1:BW], lo_nxt};

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op    <= OP_NONE;
      s1_addr  <= '0;
      bst_live <= 1'b0;
      bst_wr   <= 1'b0;
      bst_addr <= '0;
    end else if (step_en) begin
      if (!ld_n) begin
        if (sel_ok) begin
          s1_op    <= wr_n ? OP_RD : OP_WR;
          s1_addr  <= addr;
          bst_live <= 1'b1;
          bst_wr   <= ~wr_n;
          bst_addr <= addr;
        end else begin
          s1_op    <= OP_NONE;
          bst_live <= 1'b0;
        end
      end else if (bst_live) begin
        s1_op    <= bst_wr ? OP_WR : OP_RD;
        s1_addr  <= adv_addr;
        bst_addr <= adv_addr;
      end else begin
        s1_op <= OP_NONE;
      end
    end
  end

endmodule

// File: rtl/pipe_sram_lane.sv
module pipe_sram_lane #(
  parameter int AW = 6,
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] wdata,
  output logic [LW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [LW-1:0] mem [DEPTH];

  // single-port array with registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      if (re) rdata <= mem[addr];
    end
  end

endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9,
  parameter int BW    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clk_en_n,
  input  logic                sel1_n,
  input  logic                sel2,
  input  logic                sel3_n,
  input  logic                ld_n,
  input  logic                wr_n,
  input  logic [LANES-1:0]    be_n,
  input  logic [AW-1:0]       addr,
  input  logic                out_en_n,
  input  logic [LANES*LW-1:0] dq_in,
  output logic [LANES*LW-1:0] dq_out,
  output logic                dq_oe
);

  localparam int DW = LANES * LW;

  logic          step_en;
  logic          sel_ok;
  op_e           s1_op;
  logic [AW-1:0] s1_addr;
  logic          rd_go;
  logic          wr_go;
  logic          out_live;

  assign step_en = ~clk_en_n;
  assign sel_ok  = ~sel1_n & sel2 & ~sel3_n;
  assign rd_go   = step_en & (s1_op == OP_RD);
  assign wr_go   = step_en & (s1_op == OP_WR);

  pipe_sram_ctrl #(.AW(AW), .BW(BW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .sel_ok  (sel_ok),
    .ld_n    (ld_n),
    .wr_n    (wr_n),
    .addr    (addr),
    .s1_op   (s1_op),
    .s1_addr (s1_addr)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pipe_sram_lane #(.AW(AW), .LW(LW)) u_lane (
      .clk   (clk),
      .en    (step_en),
      .we    (wr_go & ~be_n[i]),
      .re    (rd_go),
      .addr  (s1_addr),
      .wdata (dq_in[i*LW +: LW]),
      .rdata (dq_out[i*LW +: LW])
    );
  end

  // output stage tracks whether the word in the output register is a read result
  always_ff @(posedge clk) begin
    if (rst) out_live <= 1'b0;
    else if (step_en) out_live <= (s1_op == OP_RD);
  end

  assign dq_oe = out_live & ~out_en_n;

endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst,
  input logic          clk_en_n,
  input logic          sel1_n,
  input logic          sel2,
  input logic          sel3_n,
  input logic          ld_n,
  input logic          wr_n,
  input logic          out_en_n,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe
);

  logic sel_ok, go_rd, go_wr, go_off;
  assign sel_ok = !sel1_n && sel2 && !sel3_n;
  assign go_rd  = !clk_en_n && !ld_n && sel_ok && wr_n;
  assign go_wr  = !clk_en_n && !ld_n && sel_ok && !wr_n;
  assign go_off = !clk_en_n && !ld_n && !sel_ok;

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !dq_oe);

  p_read_drives_r2: assert property (@(posedge clk) disable iff (rst)
    go_rd ##1 !clk_en_n |=> (out_en_n || dq_oe));

  p_write_release_r5: assert property (@(posedge clk) disable iff (rst)
    go_wr ##1 !clk_en_n |=> !dq_oe);

  p_deselect_pipe_r6: assert property (@(posedge clk) disable iff (rst)
    go_off ##1 !clk_en_n |=> !dq_oe);

  p_oe_gate_r7: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> !dq_oe);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (clk_en_n && !$isunknown(dq_out)) |=> $stable(dq_out));

endmodule

bind pipe_sram pipe_sram_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clk_en_n (clk_en_n),
  .sel1_n   (sel1_n),
  .sel2     (sel2),
  .sel3_n   (sel3_n),
  .ld_n     (ld_n),
  .wr_n     (wr_n),
  .out_en_n (out_en_n),
  .dq_out   (dq_out),
  .dq_oe    (dq_oe)
);

// File: tb/sim_pipe_sram.sv
module sim_pipe_sram;

  localparam int CLK_P = 10;
  localparam int AW = 6;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_en_n = 1'b0;
  logic sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
  logic ld_n = 1'b0, wr_n = 1'b1;
  logic [3:0] be_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic out_en_n = 1'b0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [DW-1:0] mdl [1<<AW];
  int prev_kind = 0;
  logic [AW-1:0] prev_addr = '0;
  string prev_tag = "R1";
  bit bst_live = 0, bst_wr = 0;
  logic [AW-1:0] bst_addr = '0;
  logic [DW-1:0] pend_data = '0;
  logic [3:0] pend_be = 4'hF;

  pipe_sram u0 (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .ld_n(ld_n), .wr_n(wr_n), .be_n(be_n), .addr(addr),
    .out_en_n(out_en_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'(64'h9_1357_9BDF) ^ DW'(a * 36'h1_0305_0709) ^ DW'(salt * 36'h2_4681_0ACE);
  endfunction

  // kind: 0 deselect, 1 read, 2 write, 3 advance
  task automatic step(input int kind, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input logic [3:0] be, input string tag);
    int nk;
    logic [AW-1:0] na;
    nk = 0;
    na = a;
    clk_en_n = 1'b0;
    sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
    ld_n = (kind == 3);
    wr_n = (kind != 2);
    addr = a;
    dq_in = pend_data;
    be_n = pend_be;
    if (kind == 0) begin
      if (a[1:0] == 2'd0) sel1_n = 1'b1;
      else if (a[1:0] == 2'd1) sel2 = 1'b0;
      else sel3_n = 1'b1;
    end
    if (kind == 3) begin
      sel1_n = 1'b1; sel2 = 1'b0; wr_n = a[0]; addr = ~a;
    end
    if (kind == 1 || kind == 2) begin
      nk = kind; bst_live = 1; bst_wr = (kind == 2); bst_addr = a;
    end else if (kind == 0) begin
      bst_live = 0;
    end else if (bst_live) begin
      bst_addr = {bst_addr[AW-1:2], 2'(bst_addr[1:0] + 2'd1)};
      nk = bst_wr ? 2 : 1;
      na = bst_addr;
    end
    @(posedge clk); #1;
    if (prev_kind == 2)
      for (int i = 0; i < 4; i++)
        if (!pend_be[i]) mdl[prev_addr][i*9 +: 9] = pend_data[i*9 +: 9];
    chk(dq_oe == ((prev_kind == 1) && !out_en_n), prev_tag, DW'(dq_oe), DW'((prev_kind == 1) && !out_en_n));
    if (prev_kind == 1 && !out_en_n)
      chk(dq_out === mdl[prev_addr], prev_tag, dq_out, mdl[prev_addr]);
    prev_kind = nk;
    prev_addr = na;
    prev_tag = tag;
    pend_data = wd;
    pend_be = be;
  endtask

  task automatic stall(input string tag);
    logic [DW-1:0] o_d;
    logic o_e;
    o_d = dq_out;
    o_e = dq_oe;
    clk_en_n = 1'b1;
    ld_n = 1'b0; sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0; wr_n = 1'b0;
    addr = ~addr; dq_in = ~pend_data; be_n = 4'h0;
    @(posedge clk); #1;
    chk(dq_out === o_d, tag, dq_out, o_d);
    chk(dq_oe == o_e, tag, DW'(dq_oe), DW'(o_e));
  endtask

  initial begin
    // R1: reset quiet
    rst = 1'b1;
    repeat (3) begin
      @(posedge clk); #1;
      chk(dq_oe == 1'b0, "R1", DW'(dq_oe), '0);
    end
    rst = 1'b0;
    step(0, 6'd0, '0, 4'hF, "R1");
    step(0, 6'd1, '0, 4'hF, "R1");

    // R3: full write sweep, data a cycle after address
    for (int a = 0; a < 64; a++) step(2, 6'(a), pat(a, 0), 4'h0, "R3");
    // R2: read sweep
    for (int a = 0; a < 64; a++) step(1, 6'(a), '0, 4'hF, "R2");
    step(0, 6'd2, '0, 4'hF, "R2");

    // R8: back-to-back write then read of same address, alternating
    for (int a = 0; a < 64; a += 3) begin
      step(2, 6'(a), pat(a, 7), 4'h0, "R8");
      step(1, 6'(a), '0, 4'hF, "R8");
    end
    step(0, 6'd0, '0, 4'hF, "R8");

    // R4: all lane masks
    for (int m = 0; m < 16; m++) begin
      step(2, 6'd9, pat(m, 1), 4'h0, "R4");
      step(2, 6'd9, pat(m, 2), 4'(m), "R4");
      step(1, 6'd9, '0, 4'hF, "R4");
    end
    step(0, 6'd1, '0, 4'hF, "R4");

    // R5: read, write, read: bus released after the write
    step(1, 6'd3, '0, 4'hF, "R5");
    step(2, 6'd4, pat(4, 3), 4'h0, "R5");
    step(1, 6'd4, '0, 4'hF, "R5");
    step(0, 6'd2, '0, 4'hF, "R5");

    // R6: deselect after read, read still driven one cycle then released
    step(1, 6'd10, '0, 4'hF, "R6");
    step(0, 6'd0, '0, 4'hF, "R6");
    step(0, 6'd1, '0, 4'hF, "R6");

    // R7: asynchronous output enable
    out_en_n = 1'b1;
    step(1, 6'd11, '0, 4'hF, "R7");
    step(0, 6'd2, '0, 4'hF, "R7");
    out_en_n = 1'b0; #1;
    chk(dq_oe == 1'b1, "R7", DW'(dq_oe), DW'(1));
    chk(dq_out === mdl[11], "R7", dq_out, mdl[11]);
    out_en_n = 1'b1; #1;
    chk(dq_oe == 1'b0, "R7", DW'(dq_oe), '0);
    out_en_n = 1'b0;
    step(0, 6'd0, '0, 4'hF, "R7");

    // R10: bursts of reads and writes from every starting offset
    for (int lo = 0; lo < 4; lo++) begin
      step(2, 6'(20 + lo), pat(lo, 4), 4'h0, "R10");
      for (int k = 1; k < 5; k++) step(3, 6'(k), pat(lo * 8 + k, 5), 4'h0, "R10");
      step(1, 6'(20 + lo), '0, 4'hF, "R10");
      for (int k = 1; k < 6; k++) step(3, 6'(k), '0, 4'hF, "R10");
      step(0, 6'd1, '0, 4'hF, "R10");
    end

    // R11: advance after deselect does nothing
    step(0, 6'd0, '0, 4'hF, "R11");
    for (int k = 0; k < 4; k++) step(3, 6'(k), pat(k, 6), 4'h0, "R11");
    for (int a = 0; a < 64; a += 7) step(1, 6'(a), '0, 4'hF, "R11");
    step(0, 6'd1, '0, 4'hF, "R11");

    // R9: stalls hold output and defer write data
    step(1, 6'd30, '0, 4'hF, "R9");
    step(2, 6'd31, pat(31, 9), 4'h0, "R9");
    stall("R9");
    stall("R9");
    step(1, 6'd31, '0, 4'hF, "R9");
    stall("R9");
    step(1, 6'd30, '0, 4'hF, "R9");
    stall("R9");
    step(0, 6'd2, '0, 4'hF, "R9");
    step(0, 6'd0, '0, 4'hF, "R9");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule